// File: doc/BRIEF.md
# Posted-Write Timer Register Bridge

This block joins a fast bus clock domain to a slower functional clock domain that holds ten timer registers. A bus write to one of those registers is captured on the bus side and carried over by its own toggle request and acknowledge pair. Each pair crosses through two-flop synchronisers in both directions. While a transfer is in flight, that register's bit in a readable pending-status word stays set. Four local registers live in the bus domain and take writes at once, without any crossing: interface control, wakeup enable, capture, and the pending status itself, which is read-only.

Bit 2 of the interface-control register selects the write mode. With the bit set, writes are posted: the bus sees ready in the same cycle, and software polls the pending bit before it writes that register again. With the bit clear, the bus ready is held low until the acknowledge returns. A write to a register whose earlier transfer is still in flight waits on the bus in both modes, so no value is ever dropped.

Reads of the timer registers are served from a bus-side shadow copy. The functional domain refreshes that copy through a snapshot handshake of its own. The functional registers are also brought out as a flat port, where the timer logic uses them.

Top module: `tpb_bridge`

## Requirements
- R1: After reset, the pending-status word reads 0, interface control reads 0 (non-posted mode), every timer register reads 0 and `fn_regs` is all zero.
- R2: Byte address map:
  - Interface control is at 0x10.
  - Timer register k (k = 0..9: control, counter, load, trigger, match, positive increment, negative increment, tick count, overflow-mask set, overflow-mask count) is at 0x14 + 4k.
  - Wakeup enable is at 0x3C and capture is at 0x40.
  - Pending status is at 0x48, with bit k belonging to timer register k.
  - Reads complete in the request cycle. Unmapped or misaligned addresses read 0.
  - Writes to the pending status or to unmapped addresses have no effect.
- R3: Pending bit k rises only in the cycle after a write to register k is taken. It stays set until the functional domain's acknowledge has been synchronised back.
- R4: With interface-control bit 2 set, a write to a timer register whose pending bit is clear gets `bus_ready` in its first cycle.
- R5: A write to a timer register whose pending bit is set keeps `bus_ready` low until that bit clears, and then lands. The later value is the one finally held.
- R6: With interface-control bit 2 clear, a timer-register write holds `bus_ready` low until the acknowledge returns. When ready rises, `fn_regs` already holds the value and the pending bit is clear.
- R7: Interface control, wakeup enable and capture are written in the request cycle, read back as written and leave the pending-status word unchanged.
- R8: A launched value appears in `fn_regs` at the third rising functional-clock edge after the launching bus edge. It is unchanged after the second.
- R9: Once the snapshot path has settled, a read of timer register k returns the value held in the functional domain.

Port order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-domain clock |
| rst_bus_n | input | 1 | Bus-domain reset, active low |
| clk_fn | input | 1 | Functional-domain clock |
| rst_fn_n | input | 1 | Functional-domain reset, active low |
| bus_req | input | 1 | Transfer request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Transfer completes in this cycle |
| bus_rdata | output | 32 | Read data, valid with ready |
| fn_regs | output | 320 | Functional-domain register bank, register k at bits 32k+31:32k |

## Verification
The hardest states to reach are the ones inside the crossing window. These are a second write arriving while the same register is still pending, and all ten pending bits being set at once. The functional clock runs ten times slower than the bus clock, so the bench can issue back-to-back posted writes well inside one round trip and observe the stall and the full pending word. Landing latency is measured by counting functional-clock edges after a launch. The functional clock phase is chosen so that none of its edges falls between a launch edge and the bench's sampling point.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    // Local (bus-domain) register addresses
    localparam int ADDR_IFCTL = 32'h10;
    localparam int FN_BASE    = 32'h14;
    // Offsets from FN_BASE
    localparam int OFS_WAKE   = 32'h28;
    localparam int OFS_CAPT   = 32'h2C;
    localparam int OFS_PEND   = 32'h34;
    // Interface-control bit selecting posted writes
    localparam int POSTED_BIT = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IFCTL,
        ACC_WAKE,
        ACC_CAPT,
        ACC_PEND,
        ACC_FN
    } acc_e;
endpackage

// File: rtl/tpb_sync.sv
module tpb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tpb_bus_side.sv
module tpb_bus_side
    import tpb_pkg::*;
#(
    parameter int NREG = 10,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic                     bus_ready,
    output logic [DW-1:0]            bus_rdata,
    output logic [NREG-1:0]          req_tgl,
    output logic [NREG-1:0][DW-1:0]  wr_data,
    input  logic [NREG-1:0]          ack_sync,
    input  logic                     snap_sync,
    input  logic [NREG-1:0][DW-1:0]  snap_data,
    output logic                     snap_ack,
    output logic [NREG-1:0]          pend,
    output logic                     posted,
    output logic                     np_wait
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0]         req_tgl;
        logic [NREG-1:0][DW-1:0] wdat;
        logic [NREG-1:0][DW-1:0] shadow;
        logic [DW-1:0]           ifctl;
        logic [DW-1:0]           wake;
        logic [DW-1:0]           capt;
        logic                    np_wait;
        logic                    snap_seen;
    } bstate_t;

    bstate_t      s_d, s_q;
    acc_e         sel;
    logic [AW-1:0] off;
    logic [IW-1:0] idx;
    logic          pend_sel;

    assign pend     = s_q.req_tgl ^ ack_sync;
    assign posted   = s_q.ifctl[POSTED_BIT];
    assign np_wait  = s_q.np_wait;
    assign req_tgl  = s_q.req_tgl;
    assign wr_data  = s_q.wdat;
    assign snap_ack = s_q.snap_seen;

    // Address decode
    always_comb begin
        off = bus_addr - AW'(FN_BASE);
        sel = ACC_NONE;
        idx = '0;
        if (bus_addr == AW'(ADDR_IFCTL))                sel = ACC_IFCTL;
        else if (bus_addr == AW'(FN_BASE + OFS_WAKE))   sel = ACC_WAKE;
        else if (bus_addr == AW'(FN_BASE + OFS_CAPT))   sel = ACC_CAPT;
        else if (bus_addr == AW'(FN_BASE + OFS_PEND))   sel = ACC_PEND;
        else if (bus_addr >= AW'(FN_BASE) && off < AW'(4 * NREG)
                 && off[1:0] == 2'b00) begin
            sel = ACC_FN;
            idx = IW'(off >> 2);
        end
        pend_sel = (sel == ACC_FN) ? pend[idx] : 1'b0;
    end

    // Next-state and bus response
    always_comb begin
        s_d       = s_q;
        bus_ready = 1'b0;
        bus_rdata = '0;

        // Snapshot arrival from the functional domain
        if (snap_sync != s_q.snap_seen) begin
            s_d.shadow    = snap_data;
            s_d.snap_seen = snap_sync;
        end

        if (bus_req) begin
            if (!bus_we) begin
                bus_ready = 1'b1;
                case (sel)
                    ACC_IFCTL: bus_rdata = s_q.ifctl;
                    ACC_WAKE:  bus_rdata = s_q.wake;
                    ACC_CAPT:  bus_rdata = s_q.capt;
                    ACC_PEND:  bus_rdata = DW'(pend);
                    ACC_FN:    bus_rdata = s_q.shadow[idx];
                    default:   bus_rdata = '0;
                endcase
            end else begin
                case (sel)
                    ACC_IFCTL: begin s_d.ifctl = bus_wdata; bus_ready = 1'b1; end
                    ACC_WAKE:  begin s_d.wake  = bus_wdata; bus_ready = 1'b1; end
                    ACC_CAPT:  begin s_d.capt  = bus_wdata; bus_ready = 1'b1; end
                    ACC_FN: begin
                        if (s_q.np_wait) begin
                            if (!pend_sel) begin
                                bus_ready   = 1'b1;
                                s_d.np_wait = 1'b0;
                            end
                        end else if (!pend_sel) begin
                            s_d.wdat[idx]    = bus_wdata;
                            s_d.req_tgl[idx] = ~s_q.req_tgl[idx];
                            if (posted) bus_ready   = 1'b1;
                            else        s_d.np_wait = 1'b1;
                        end
                    end
                    default: bus_ready = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tpb_fn_side.sv
module tpb_fn_side #(
    parameter int NREG = 10,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          req_sync,
    input  logic [NREG-1:0][DW-1:0]  wr_data,
    output logic [NREG-1:0]          ack_tgl,
    input  logic                     snap_ack_sync,
    output logic                     snap_tgl,
    output logic [NREG-1:0][DW-1:0]  snap_data,
    output logic [NREG-1:0][DW-1:0]  bank
);
    typedef struct packed {
        logic [NREG-1:0]         seen;
        logic [NREG-1:0][DW-1:0] bank;
        logic [NREG-1:0][DW-1:0] snap;
        logic                    snap_tgl;
    } fstate_t;

    fstate_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        // Land each register whose request toggle has moved
        for (int k = 0; k < NREG; k++) begin
            if (req_sync[k] != f_q.seen[k]) begin
                f_d.bank[k] = wr_data[k];
                f_d.seen[k] = req_sync[k];
            end
        end
        // New snapshot once the previous one has been taken
        if (snap_ack_sync == f_q.snap_tgl) begin
            f_d.snap     = f_q.bank;
            f_d.snap_tgl = ~f_q.snap_tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ack_tgl   = f_q.seen;
    assign snap_tgl  = f_q.snap_tgl;
    assign snap_data = f_q.snap;
    assign bank      = f_q.bank;
endmodule

// File: rtl/tpb_bridge.sv
module tpb_bridge #(
    parameter int NREG   = 10,
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int STAGES = 2
) (
    input  logic               clk_bus,
    input  logic               rst_bus_n,
    input  logic               clk_fn,
    input  logic               rst_fn_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic [DW-1:0]      bus_rdata,
    output logic [NREG*DW-1:0] fn_regs
);
    logic [NREG-1:0]         req_tgl, req_sync_f;
    logic [NREG-1:0]         ack_tgl, ack_sync_b;
    logic [NREG-1:0][DW-1:0] wr_data, snap_data, bank;
    logic                    snap_tgl, snap_sync_b;
    logic                    snap_ack, snap_ack_sync_f;
    logic [NREG-1:0]         pend_w;
    logic                    posted_w, np_wait_w;

    tpb_bus_side #(.NREG(NREG), .DW(DW), .AW(AW)) u_bus (
        .clk       (clk_bus),
        .rst_n     (rst_bus_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .req_tgl   (req_tgl),
        .wr_data   (wr_data),
        .ack_sync  (ack_sync_b),
        .snap_sync (snap_sync_b),
        .snap_data (snap_data),
        .snap_ack  (snap_ack),
        .pend      (pend_w),
        .posted    (posted_w),
        .np_wait   (np_wait_w)
    );

    tpb_sync #(.W(NREG), .STAGES(STAGES)) u_req_sync (
        .clk(clk_fn), .rst_n(rst_fn_n), .din(req_tgl), .dout(req_sync_f)
    );

    tpb_sync #(.W(NREG), .STAGES(STAGES)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .din(ack_tgl), .dout(ack_sync_b)
    );

    tpb_sync #(.W(1), .STAGES(STAGES)) u_snap_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .din(snap_tgl), .dout(snap_sync_b)
    );

    tpb_sync #(.W(1), .STAGES(STAGES)) u_snap_ack_sync (
        .clk(clk_fn), .rst_n(rst_fn_n), .din(snap_ack), .dout(snap_ack_sync_f)
    );

    tpb_fn_side #(.NREG(NREG), .DW(DW)) u_fn (
        .clk           (clk_fn),
        .rst_n         (rst_fn_n),
        .req_sync      (req_sync_f),
        .wr_data       (wr_data),
        .ack_tgl       (ack_tgl),
        .snap_ack_sync (snap_ack_sync_f),
        .snap_tgl      (snap_tgl),
        .snap_data     (snap_data),
        .bank          (bank)
    );

    assign fn_regs = bank;
endmodule

// File: rtl/tpb_bridge_chk.sv
module tpb_bridge_chk
    import tpb_pkg::*;
#(
    parameter int NREG = 10,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            we,
    input logic [AW-1:0]   addr,
    input logic            ready,
    input logic [NREG-1:0] pend,
    input logic            posted,
    input logic            np_wait
);
    localparam int IW = $clog2(NREG);

    logic [AW-1:0] off;
    logic [IW-1:0] idx;
    logic          fn_hit, loc_hit, pend_sel;

    always_comb begin
        off     = addr - AW'(FN_BASE);
        fn_hit  = (addr >= AW'(FN_BASE)) && (off < AW'(4 * NREG)) && (off[1:0] == 2'b00);
        idx     = IW'(off >> 2);
        loc_hit = (addr == AW'(ADDR_IFCTL)) || (addr == AW'(FN_BASE + OFS_WAKE))
               || (addr == AW'(FN_BASE + OFS_CAPT));
        pend_sel = fn_hit ? pend[idx] : 1'b0;
    end

    // R5
    pending_write_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && fn_hit && pend_sel) |-> !ready);

    // R4
    posted_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (posted && req && we && fn_hit && !pend_sel && !np_wait) |-> ready);

    // R6
    nonposted_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!posted && req && we && fn_hit && ready) |-> np_wait);

    // R7
    local_write_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && loc_hit) |-> ready);

    genvar k;
    generate
        for (k = 0; k < NREG; k++) begin : g_pend
            // R3
            pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[k]) |-> $past(req && we && fn_hit && idx == IW'(k)));
        end
    endgenerate
endmodule

bind tpb_bridge tpb_bridge_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk     (clk_bus),
    .rst_n   (rst_bus_n),
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .ready   (bus_ready),
    .pend    (pend_w),
    .posted  (posted_w),
    .np_wait (np_wait_w)
);

// File: tb/tpb_bridge_bench.sv
module tpb_bridge_bench;
    localparam int NREG = 10;
    localparam int DW   = 32;

    logic clk_bus, clk_fn, rst_bus_n, rst_fn_n;
    logic bus_req, bus_we, bus_ready;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [NREG*DW-1:0] fn_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    tpb_bridge u_tpb_bridge (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_fn(clk_fn), .rst_fn_n(rst_fn_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .fn_regs(fn_regs)
    );

    // 250 MHz bus clock: rising edges at 2 mod 4 ns
    initial begin
        clk_bus = 0;
        forever #2 clk_bus = ~clk_bus;
    end

    // 25 MHz functional clock: rising edges at 1 mod 4 ns, never between a
    // bus rising edge and the following bus falling edge
    initial begin
        clk_fn = 0;
        #5;
        forever begin
            clk_fn = 1; #20;
            clk_fn = 0; #20;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Entered and left at a bus falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] v, output int waits);
        waits = 0;
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
        #1;
        while (!bus_ready && waits < 1000) begin
            @(negedge clk_bus); #1;
            waits++;
        end
        @(negedge clk_bus);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        int guard = 0;
        bus_req = 1; bus_we = 0; bus_addr = a;
        #1;
        while (!bus_ready && guard < 1000) begin
            @(negedge clk_bus); #1;
            guard++;
        end
        v = bus_rdata;
        @(negedge clk_bus);
        bus_req = 0;
    endtask

    task automatic wait_pend_clear();
        logic [31:0] p;
        int n = 0;
        do begin
            bus_read(8'h48, p);
            n++;
        end while (p != 0 && n < 500);
    endtask

    function automatic logic [7:0] reg_addr(input int k);
        return 8'(8'h14 + 4 * k);
    endfunction

    function automatic logic [31:0] pat_a(input int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0203;
    endfunction

    initial begin
        repeat (150000) @(posedge clk_bus);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R6: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        rst_bus_n = 0; rst_fn_n = 0;
        repeat (5) @(negedge clk_bus);
        rst_bus_n = 1; rst_fn_n = 1;
        repeat (60) @(negedge clk_bus);

        // R1 reset state
        check(fn_regs == '0, "R1 fn_regs zero", fn_regs[31:0], 32'h0);
        bus_read(8'h48, rd); check(rd == 0, "R1 pending", rd, 0);
        bus_read(8'h10, rd); check(rd == 0, "R1 ifctl", rd, 0);
        for (int k = 0; k < NREG; k++) begin
            bus_read(reg_addr(k), rd); check(rd == 0, "R1 timer reg", rd, 0);
        end

        // R6 non-posted sweep over all ten registers
        for (int k = 0; k < NREG; k++) begin
            bus_write(reg_addr(k), pat_a(k), w);
            check(w >= 8 && w < 200, "R6 stall length", 32'(w), 32'd8);
            check(fn_regs[k*DW +: DW] == pat_a(k), "R6 landed at ready", fn_regs[k*DW +: DW], pat_a(k));
            bus_read(8'h48, rd); check(rd == 0, "R6 R3 pending clear", rd, 0);
        end

        // R7 switch to posted mode via interface control
        bus_write(8'h10, 32'h4, w); check(w == 0, "R7 ifctl immediate", 32'(w), 0);
        bus_read(8'h10, rd); check(rd == 32'h4, "R7 ifctl readback", rd, 32'h4);
        bus_read(8'h48, rd); check(rd == 0, "R7 pending untouched", rd, 0);

        // R8 landing latency counted in functional-clock edges
        bus_write(reg_addr(0), 32'h0000_0001, w);
        check(w == 0, "R4 posted control", 32'(w), 0);
        @(posedge clk_fn); #1;
        @(posedge clk_fn); #1;
        check(fn_regs[31:0] == pat_a(0), "R8 not yet landed", fn_regs[31:0], pat_a(0));
        @(posedge clk_fn); #1;
        check(fn_regs[31:0] == 32'h1, "R8 landed third edge", fn_regs[31:0], 32'h1);
        @(negedge clk_bus);
        wait_pend_clear();

        // R4 R3 posted sweep inside one crossing window
        for (int k = 0; k < NREG; k++) begin
            bus_write(reg_addr(k), ~pat_a(k), w);
            check(w == 0, "R4 posted ready", 32'(w), 0);
        end
        bus_read(8'h48, rd); check(rd == 32'h3FF, "R3 all pending", rd, 32'h3FF);
        wait_pend_clear();
        bus_read(8'h48, rd); check(rd == 0, "R3 pending cleared", rd, 0);
        repeat (100) @(negedge clk_bus);
        for (int k = 0; k < NREG; k++) begin
            check(fn_regs[k*DW +: DW] == ~pat_a(k), "R4 landed", fn_regs[k*DW +: DW], ~pat_a(k));
            bus_read(reg_addr(k), rd); check(rd == ~pat_a(k), "R9 readback", rd, ~pat_a(k));
        end

        // R5 second write to a still-pending register
        bus_write(reg_addr(2), 32'h1111_1111, w); check(w == 0, "R5 first posted", 32'(w), 0);
        bus_write(reg_addr(2), 32'h2222_2222, w); check(w > 0, "R5 second stalled", 32'(w), 1);
        wait_pend_clear();
        repeat (100) @(negedge clk_bus);
        check(fn_regs[2*DW +: DW] == 32'h2222_2222, "R5 final value", fn_regs[2*DW +: DW], 32'h2222_2222);
        bus_read(reg_addr(2), rd); check(rd == 32'h2222_2222, "R5 R9 readback", rd, 32'h2222_2222);

        // R7 direct registers
        bus_write(8'h3C, 32'h0000_0007, w); check(w == 0, "R7 wake immediate", 32'(w), 0);
        bus_write(8'h40, 32'hDEAD_BEEF, w); check(w == 0, "R7 capture immediate", 32'(w), 0);
        bus_read(8'h48, rd); check(rd == 0, "R7 pending after direct", rd, 0);
        bus_read(8'h3C, rd); check(rd == 32'h7, "R7 wake readback", rd, 32'h7);
        bus_read(8'h40, rd); check(rd == 32'hDEAD_BEEF, "R7 capture readback", rd, 32'hDEAD_BEEF);

        // R2 read-only status, unmapped and misaligned addresses
        bus_write(8'h48, 32'hFFFF_FFFF, w); check(w == 0, "R2 status write completes", 32'(w), 0);
        bus_read(8'h48, rd); check(rd == 0, "R2 status read-only", rd, 0);
        bus_read(8'h00, rd); check(rd == 0, "R2 unmapped low", rd, 0);
        bus_read(8'h4C, rd); check(rd == 0, "R2 unmapped high", rd, 0);
        bus_read(8'h15, rd); check(rd == 0, "R2 misaligned", rd, 0);
        bus_write(8'h16, 32'h5555_5555, w);
        bus_read(8'h48, rd); check(rd == 0, "R2 misaligned write no launch", rd, 0);

        // R6 back to non-posted mode
        bus_write(8'h10, 32'h0, w);
        bus_write(reg_addr(4), 32'h0BAD_F00D, w);
        check(w >= 8, "R6 stall after mode change", 32'(w), 32'd8);
        check(fn_regs[4*DW +: DW] == 32'h0BAD_F00D, "R6 match landed", fn_regs[4*DW +: DW], 32'h0BAD_F00D);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule